// File: doc/BRIEF.md
# Carry-Aware Micro-Task ALU

This is a purely combinational arithmetic and logic unit for a very small datapath that is switched on only when it is needed. It takes two operand words, a carry bit and a 3-bit operation code. It returns a result word, a carry bit and a 3-bit unsigned comparison flag vector. The block holds no state: the outputs follow the inputs within the same cycle.

Eight fixed operators feed one result multiplexer, and the operation code selects among them. The operand width is a parameter. It defaults to 8 bits, and 16 bits is the other intended build. Addition and comparison share one adder. During a compare the adder subtracts, and the three flags come from its borrow and from a zero test of its output.

Top module: `uta_alu`

## Requirements
- R1: Opcode 3'b000 (add) gives result = (opnd_a + opnd_b + carry_in) mod 2^W. carry_out is the carry out of the most significant bit.
- R2: Opcode 3'b001 (invert) gives result = bitwise NOT of opnd_a.
- R3: Opcode 3'b010 (compare) gives result = (opnd_a - opnd_b) mod 2^W, and carry_in is ignored. Exactly one of the flags cmp_flags[2] (less), cmp_flags[1] (equal) and cmp_flags[0] (greater) is set, from an unsigned comparison of opnd_a with opnd_b.
- R4: Opcodes 3'b011, 3'b100 and 3'b101 give the bitwise AND, OR and XOR of the two operands.
- R5: Opcode 3'b110 (shift left) gives result = {opnd_a[W-2:0], carry_in} and carry_out = opnd_a[W-1].
- R6: Opcode 3'b111 (shift right) gives result = {carry_in, opnd_a[W-1:1]} and carry_out = opnd_a[0].
- R7: cmp_flags is 3'b000 for every opcode other than compare.
- R8: carry_out is 0 for the invert, compare, AND, OR and XOR opcodes.
- R9: opnd_b has no effect on the result or carry of invert, shift left and shift right.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Operation code |
| opnd_a | input | W | First operand |
| opnd_b | input | W | Second operand |
| carry_in | input | 1 | Carry, or the bit shifted in |
| result | output | W | Selected operator output |
| carry_out | output | 1 | Carry out of the add, or the bit shifted out |
| cmp_flags | output | 3 | {less, equal, greater}, set only during compare |

## Verification
Two conditions are rare under uniform random operands. One is a carry that ripples through every bit: an all-ones operand added to zero with the carry set. The other is the equal flag, which random operands of 8 bits almost never produce. The stimulus table therefore holds these cases directly. A directed pass also drives compares with identical random operands, and both operands at each extreme. Further directed tests change opnd_b while the opcode stays on an operator that ignores it, and check that the outputs do not move.

// File: rtl/uta_pkg.sv
package uta_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'b000,
        OP_NOT = 3'b001,
        OP_CMP = 3'b010,
        OP_AND = 3'b011,
        OP_OR  = 3'b100,
        OP_XOR = 3'b101,
        OP_SHL = 3'b110,
        OP_SHR = 3'b111
    } uta_op_e;

    typedef struct packed {
        logic lt;
        logic eq;
        logic gt;
    } uta_flags_t;

    localparam int FLAG_W = $bits(uta_flags_t);

    function automatic logic op_uses_adder(uta_op_e op);
        return (op == OP_ADD) || (op == OP_CMP);
    endfunction

endpackage

// File: rtl/uta_adder.sv
module uta_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         subtract,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W-1:0] b_eff;
    logic         c_eff;
    logic [W:0]   wide;

    assign b_eff = subtract ? ~b : b;
    assign c_eff = subtract ? 1'b1 : cin;
    assign wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
    assign sum   = wide[W-1:0];
    assign cout  = wide[W];
endmodule

// File: rtl/uta_shifter.sv
module uta_shifter #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic         fill,
    output logic [W-1:0] left,
    output logic         left_out,
    output logic [W-1:0] right,
    output logic         right_out
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign left[i]  = fill;
        end else begin : g_mid_l
            assign left[i]  = a[i-1];
        end
        if (i == W-1) begin : g_msb
            assign right[i] = fill;
        end else begin : g_mid_r
            assign right[i] = a[i+1];
        end
    end
    assign left_out  = a[W-1];
    assign right_out = a[0];
endmodule

// File: rtl/uta_logic.sv
module uta_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] inv,
    output logic [W-1:0] conj,
    output logic [W-1:0] disj,
    output logic [W-1:0] excl
);
    assign inv  = ~a;
    assign conj = a & b;
    assign disj = a | b;
    assign excl = a ^ b;
endmodule

// File: rtl/uta_flags.sv
module uta_flags #(
    parameter int W = 8
) (
    input  logic                      enable,
    input  logic [W-1:0]              diff,
    input  logic                      no_borrow,
    output uta_pkg::uta_flags_t       flags
);
    logic zero;
    assign zero = (diff == '0);

    always_comb begin
        flags = '0;
        if (enable) begin
            flags.lt = ~no_borrow;
            flags.eq = zero;
            flags.gt = no_borrow & ~zero;
        end
    end
endmodule

// File: rtl/uta_alu.sv
module uta_alu #(
    parameter int W = 8
) (
    input  logic [2:0]   op_sel,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic         carry_in,
    output logic [W-1:0] result,
    output logic         carry_out,
    output logic [2:0]   cmp_flags
);
    import uta_pkg::*;

    uta_op_e      op;
    logic         is_cmp;
    logic [W-1:0] add_sum, shl_w, shr_w, not_w, and_w, or_w, xor_w;
    logic         add_c, shl_c, shr_c;
    uta_flags_t   flg;

    assign op     = uta_op_e'(op_sel);
    assign is_cmp = (op == OP_CMP);

    uta_adder #(.W(W)) u_adder (
        .a(opnd_a), .b(opnd_b), .cin(carry_in), .subtract(is_cmp),
        .sum(add_sum), .cout(add_c)
    );

    uta_shifter #(.W(W)) u_shift (
        .a(opnd_a), .fill(carry_in),
        .left(shl_w), .left_out(shl_c), .right(shr_w), .right_out(shr_c)
    );

    uta_logic #(.W(W)) u_logic (
        .a(opnd_a), .b(opnd_b),
        .inv(not_w), .conj(and_w), .disj(or_w), .excl(xor_w)
    );

    uta_flags #(.W(W)) u_flags (
        .enable(is_cmp), .diff(add_sum), .no_borrow(add_c), .flags(flg)
    );

    always_comb begin
        carry_out = 1'b0;
        unique case (op)
            OP_ADD: begin result = add_sum; carry_out = add_c; end
            OP_NOT: result = not_w;
            OP_CMP: result = add_sum;
            OP_AND: result = and_w;
            OP_OR:  result = or_w;
            OP_XOR: result = xor_w;
            OP_SHL: begin result = shl_w; carry_out = shl_c; end
            OP_SHR: begin result = shr_w; carry_out = shr_c; end
            default: result = '0;
        endcase
    end

    assign cmp_flags = flg;
endmodule

// File: rtl/uta_alu_checker.sv
module uta_alu_checker #(
    parameter int W = 8
) (
    input logic [2:0]   op_sel,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic         carry_in,
    input logic [W-1:0] result,
    input logic         carry_out,
    input logic [2:0]   cmp_flags
);
    logic [W:0] wide_add;
    assign wide_add = {1'b0, opnd_a} + {1'b0, opnd_b} + {{W{1'b0}}, carry_in};

    always_comb begin
        if (!$isunknown({op_sel, opnd_a, opnd_b, carry_in})) begin
            if (op_sel == 3'b000)
                a_r1_add_sum: assert ({carry_out, result} == wide_add);
            if (op_sel == 3'b010) begin
                a_r3_one_flag: assert ($onehot(cmp_flags));
                a_r3_eq_match: assert (cmp_flags[1] == (opnd_a == opnd_b));
            end
            if (op_sel != 3'b010)
                a_r7_flags_idle: assert (cmp_flags == 3'b000);
            if (op_sel == 3'b110)
                a_r5_shl_out: assert (carry_out == opnd_a[W-1] && result[0] == carry_in);
            if (op_sel == 3'b111)
                a_r6_shr_out: assert (carry_out == opnd_a[0] && result[W-1] == carry_in);
            if (op_sel >= 3'b001 && op_sel <= 3'b101)
                a_r8_no_carry: assert (carry_out == 1'b0);
        end
    end
endmodule

bind uta_alu uta_alu_checker #(.W(W)) u_chk (
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in),
    .result(result), .carry_out(carry_out), .cmp_flags(cmp_flags)
);

// File: tb/uta_alu_bench.sv
module uta_alu_bench;
    localparam int W = 8;
    localparam int PERIOD = 10;
    localparam int NVEC = 16;

    // {op[2:0], a[7:0], b[7:0], cin, res[7:0], cout, flags[2:0]}
    localparam logic [31:0] VEC [NVEC] = '{
        {3'd0, 8'h12, 8'h34, 1'b0, 8'h46, 1'b0, 3'b000},
        {3'd0, 8'hFF, 8'h00, 1'b1, 8'h00, 1'b1, 3'b000},
        {3'd0, 8'h80, 8'h80, 1'b0, 8'h00, 1'b1, 3'b000},
        {3'd0, 8'h7F, 8'h01, 1'b1, 8'h81, 1'b0, 3'b000},
        {3'd1, 8'h5A, 8'hFF, 1'b1, 8'hA5, 1'b0, 3'b000},
        {3'd2, 8'h10, 8'h20, 1'b1, 8'hF0, 1'b0, 3'b100},
        {3'd2, 8'h33, 8'h33, 1'b0, 8'h00, 1'b0, 3'b010},
        {3'd2, 8'hFF, 8'h00, 1'b0, 8'hFF, 1'b0, 3'b001},
        {3'd3, 8'hF0, 8'h3C, 1'b1, 8'h30, 1'b0, 3'b000},
        {3'd4, 8'hF0, 8'h0F, 1'b0, 8'hFF, 1'b0, 3'b000},
        {3'd5, 8'hAA, 8'hFF, 1'b1, 8'h55, 1'b0, 3'b000},
        {3'd6, 8'h81, 8'h00, 1'b0, 8'h02, 1'b1, 3'b000},
        {3'd6, 8'h40, 8'hFF, 1'b1, 8'h81, 1'b0, 3'b000},
        {3'd7, 8'h81, 8'h00, 1'b0, 8'h40, 1'b1, 3'b000},
        {3'd7, 8'h02, 8'hFF, 1'b1, 8'h81, 1'b0, 3'b000},
        {3'd2, 8'h00, 8'h01, 1'b1, 8'hFF, 1'b0, 3'b100}
    };

    logic clk = 1'b0;
    always #(PERIOD/2) clk = ~clk;

    logic [2:0]   op_sel;
    logic [W-1:0] opnd_a, opnd_b, result;
    logic         carry_in, carry_out;
    logic [2:0]   cmp_flags;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    uta_alu #(.W(W)) u_uta_alu (
        .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in),
        .result(result), .carry_out(carry_out), .cmp_flags(cmp_flags)
    );

    function automatic string tag_of(logic [2:0] op);
        case (op)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd6: return "R5";
            3'd7: return "R6";
            default: return "R4";
        endcase
    endfunction

    // Reference model written from the requirements: {res, cout, flags}
    function automatic logic [W+3:0] model(logic [2:0] op, logic [W-1:0] a,
                                           logic [W-1:0] b, logic c);
        logic [W:0]   s;
        logic [W-1:0] r;
        logic         co;
        logic [2:0]   f;
        co = 1'b0; f = 3'b000;
        case (op)
            3'd0: begin s = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c}; r = s[W-1:0]; co = s[W]; end
            3'd1: r = ~a;
            3'd2: begin
                r = a - b;
                f = (a < b) ? 3'b100 : ((a == b) ? 3'b010 : 3'b001);
            end
            3'd3: r = a & b;
            3'd4: r = a | b;
            3'd5: r = a ^ b;
            3'd6: begin r = {a[W-2:0], c}; co = a[W-1]; end
            default: begin r = {c, a[W-1:1]}; co = a[0]; end
        endcase
        return {r, co, f};
    endfunction

    task automatic apply(input logic [2:0] op, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic c,
                         input logic [W+3:0] exp, input string tag);
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; carry_in = c;
        #(PERIOD/4);
        n_vec++;
        if ({result, carry_out, cmp_flags} !== exp) begin
            n_bad++;
            $display("FAIL %s op=%0d a=%h b=%h cin=%b: got res=%h c=%b f=%b, exp res=%h c=%b f=%b",
                     tag, op, a, b, c, result, carry_out, cmp_flags,
                     exp[W+3:4], exp[3], exp[2:0]);
        end
    endtask

    initial begin
        op_sel = '0; opnd_a = '0; opnd_b = '0; carry_in = 1'b0;
        // idle inputs: add of zeros gives all-zero outputs (R1, R7)
        apply(3'd0, 8'h00, 8'h00, 1'b0, 12'h000, "R1 idle");

        for (int i = 0; i < NVEC; i++) begin
            logic [31:0] v;
            v = VEC[i];
            apply(v[31:29], v[28:21], v[20:13], v[12], v[11:0], tag_of(v[31:29]));
        end

        // random sweep over every opcode; flags and carry rules R7, R8
        for (int k = 0; k < 1600; k++) begin
            logic [2:0]   op;
            logic [W-1:0] a, b;
            logic         c;
            op = 3'(k % 8);
            a = W'($urandom); b = W'($urandom); c = 1'($urandom);
            apply(op, a, b, c, model(op, a, b, c),
                  (op == 3'd2) ? "R3" : ((op == 3'd0 || op >= 3'd6) ? tag_of(op) : "R8/R7"));
        end

        // compare equal operands and extremes (R3)
        for (int k = 0; k < 40; k++) begin
            logic [W-1:0] a;
            a = W'($urandom);
            apply(3'd2, a, a, 1'($urandom), {8'h00, 1'b0, 3'b010}, "R3 equal");
        end
        apply(3'd2, 8'h00, 8'hFF, 1'b0, {8'h01, 1'b0, 3'b100}, "R3 min-max");
        apply(3'd2, 8'hFF, 8'hFE, 1'b1, {8'h01, 1'b0, 3'b001}, "R3 near-max");
        apply(3'd2, 8'h80, 8'h7F, 1'b0, {8'h01, 1'b0, 3'b001}, "R3 unsigned");

        // full ripple with carry in (R1)
        apply(3'd0, 8'hFF, 8'hFF, 1'b1, {8'hFF, 1'b1, 3'b000}, "R1 max");
        apply(3'd0, 8'h00, 8'h00, 1'b1, {8'h01, 1'b0, 3'b000}, "R1 cin only");

        // opnd_b ignored by invert and both shifts (R9)
        for (int k = 0; k < 3; k++) begin
            logic [2:0] op;
            op = (k == 0) ? 3'd1 : ((k == 1) ? 3'd6 : 3'd7);
            apply(op, 8'hC3, 8'h00, 1'b1, model(op, 8'hC3, 8'h00, 1'b1), "R9 b=00");
            apply(op, 8'hC3, 8'hFF, 1'b1, model(op, 8'hC3, 8'h00, 1'b1), "R9 b=FF");
            apply(op, 8'hC3, 8'h5A, 1'b1, model(op, 8'hC3, 8'h00, 1'b1), "R9 b=5A");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule